// File: doc/BRIEF.md
# Sleep-Mode Pin Hold Controller

This block decides who drives a bank of 22 shared pads. In normal running, each pad follows its peripheral. The peripheral's output enable is gated by a run-direction register, and the peripheral's data passes straight through.

Software also programs a second register, the sleep-direction register. It is captured into a hold latch at the moment the chip enters sleep. From then until software releases the pads, every pad is either driven low or left as an input, according to that latch. Off-chip inputs therefore never float while the core is down.

The run-direction register is lost on every kind of reset, sleep entry included. The sleep-direction register survives everything except a hard reset. After wake-up a sticky hold flag keeps the pads frozen. This gives software time to reprogram the peripherals. Software then writes a one to the flag to hand the pads back.

Top module: `pin_hold_ctl`

## Requirements
- R1: The three registers sit at byte offsets 0x00 (run direction, bits 21:0), 0x0C (sleep direction, bits 21:0) and 0x10 (hold flag in bit 0). Bit n of either direction register controls pad n. A read issued in one cycle returns its data on the following cycle. When no read is requested, the read data is zero.
- R2: Writes to bits 31:22 of the direction registers have no effect. Those bits, and bits 31:1 of the hold register, read as zero.
- R3: The run-direction register becomes zero after a hard reset, a soft reset, a sleep reset or a sleep-entry strobe. A zero makes the pad an input in normal running.
- R4: Soft reset and sleep reset leave the sleep-direction register unchanged.
- R5: Hard reset sets all 22 sleep-direction bits to one. It also clears the hold flag and the sleep state.
- R6: While asleep or while the hold flag is set, pad n is an input when its latched bit is one. It is driven low (pad_oe=1, pad_do=0) when its latched bit is zero.
- R7: The hold latch takes the sleep-direction value at the sleep-entry strobe. Later writes to the sleep-direction register do not change the pads until the next sleep entry.
- R8: The hold flag sets on the sleep-exit strobe. While it is set, the pads ignore per_oe and per_do.
- R9: Writing a one to bit 0 of the hold register clears the hold flag, and writing a zero leaves it set. A sleep-exit strobe in the same cycle wins over the clear.
- R10: Outside sleep and hold, pad_oe equals run-direction AND per_oe, and pad_do equals per_do.
- R11: A power-loss strobe sets every hold-latch bit to one, so that all pads read as inputs until the next sleep entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| sleep_rst | input | 1 | Sleep reset to the pin controller |
| sleep_enter | input | 1 | One-cycle strobe: core enters sleep |
| sleep_exit | input | 1 | One-cycle strobe: core leaves sleep |
| power_loss | input | 1 | One-cycle strobe: main supply removed |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| per_oe | input | 22 | Peripheral output enables |
| per_do | input | 22 | Peripheral output data |
| pad_oe | output | 22 | Pad output enables |
| pad_do | output | 22 | Pad output data |

## Verification
The sleep path is swept with a walking zero over all 22 sleep-direction bits. This shows that each bit reaches its own pad and no neighbour, and that a later rewrite of the register is masked by the latch. The normal path is swept with walking single bits in run direction against all-ones and walking-hole peripheral enables. That sweep separates gating by direction from gating by the peripheral. Separate sequences drive all-ones writes for the reserved bits, and resets of each kind for persistence. A sleep exit coinciding with a hold clear tests precedence, and a power loss during sleep tests the latch reset.

// File: rtl/pin_hold_ctl.sv
module pin_hold_ctl #(
  parameter int NPINS = 22,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] RUN_OFS  = 8'h00,
  parameter logic [AW-1:0] SLP_OFS  = 8'h0C,
  parameter logic [AW-1:0] HOLD_OFS = 8'h10
) (
  input  logic             clk,
  input  logic             hard_rst,
  input  logic             soft_rst,
  input  logic             sleep_rst,
  input  logic             sleep_enter,
  input  logic             sleep_exit,
  input  logic             power_loss,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] per_oe,
  input  logic [NPINS-1:0] per_do,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do
);
  localparam logic [NPINS-1:0] ONES = '1;

  logic [NPINS-1:0] run_dir, slp_dir, hold_lat;
  logic asleep, hold;
  logic [DW-1:0] rd_mux;

  wire wr_run  = bus_sel & bus_wr & (bus_addr == RUN_OFS);
  wire wr_slp  = bus_sel & bus_wr & (bus_addr == SLP_OFS);
  wire wr_hold = bus_sel & bus_wr & (bus_addr == HOLD_OFS);
  wire hold_clr = wr_hold & bus_wdata[0];
  wire pin_lock = asleep | hold;
  wire unused_wdata = ^bus_wdata[DW-1:NPINS];

  always_ff @(posedge clk)
    if (hard_rst | soft_rst | sleep_rst | sleep_enter) run_dir <= '0;
    else if (wr_run) run_dir <= bus_wdata[NPINS-1:0];

  always_ff @(posedge clk)
    if (hard_rst) slp_dir <= ONES;
    else if (wr_slp) slp_dir <= bus_wdata[NPINS-1:0];

  always_ff @(posedge clk)
    if (hard_rst | power_loss) hold_lat <= ONES;
    else if (sleep_enter) hold_lat <= slp_dir;

  always_ff @(posedge clk)
    if (hard_rst) asleep <= 1'b0;
    else if (sleep_enter) asleep <= 1'b1;
    else if (sleep_exit) asleep <= 1'b0;

  always_ff @(posedge clk)
    if (hard_rst) hold <= 1'b0;
    else if (sleep_exit) hold <= 1'b1;
    else if (hold_clr) hold <= 1'b0;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == RUN_OFS) rd_mux[NPINS-1:0] = run_dir;
    else if (bus_addr == SLP_OFS) rd_mux[NPINS-1:0] = slp_dir;
    else if (bus_addr == HOLD_OFS) rd_mux[0] = hold;
  end

  always_ff @(posedge clk)
    if (hard_rst) bus_rdata <= '0;
    else if (bus_sel & ~bus_wr) bus_rdata <= rd_mux;
    else bus_rdata <= '0;

  assign pad_oe = pin_lock ? ~hold_lat : (run_dir & per_oe);
  assign pad_do = pin_lock ? '0 : per_do;
endmodule

module pin_hold_ctl_chk #(
  parameter int NPINS = 22,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] SLP_OFS  = 8'h0C,
  parameter logic [AW-1:0] HOLD_OFS = 8'h10
) (
  input logic             clk,
  input logic             hard_rst,
  input logic             soft_rst,
  input logic             sleep_rst,
  input logic             sleep_enter,
  input logic             sleep_exit,
  input logic             power_loss,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_do,
  input logic [NPINS-1:0] run_dir,
  input logic [NPINS-1:0] slp_dir,
  input logic [NPINS-1:0] hold_lat,
  input logic             hold
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (hard_rst)
    bus_rdata[DW-1:NPINS] == '0);

  a_r3_run_cleared: assert property (@(posedge clk) disable iff (hard_rst)
    (soft_rst || sleep_rst || sleep_enter) |=> run_dir == '0);

  a_r4_sleep_dir_kept: assert property (@(posedge clk) disable iff (hard_rst)
    ((soft_rst || sleep_rst) && !(bus_sel && bus_wr && bus_addr == SLP_OFS))
      |=> $stable(slp_dir));

  a_r6_sleep_pads: assert property (@(posedge clk) disable iff (hard_rst)
    (sleep_enter && !power_loss) |=> (pad_oe == ~$past(slp_dir) && pad_do == '0));

  a_r8_hold_sets: assert property (@(posedge clk) disable iff (hard_rst)
    sleep_exit |=> hold);

  a_r9_hold_sticky: assert property (@(posedge clk) disable iff (hard_rst)
    (hold && !sleep_exit && !(bus_sel && bus_wr && bus_addr == HOLD_OFS && bus_wdata[0]))
      |=> hold);

  a_r11_power_loss: assert property (@(posedge clk) disable iff (hard_rst)
    power_loss |=> hold_lat == '1);
endmodule

bind pin_hold_ctl pin_hold_ctl_chk #(
  .NPINS(NPINS), .AW(AW), .DW(DW), .SLP_OFS(SLP_OFS), .HOLD_OFS(HOLD_OFS)
) u_chk (
  .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .sleep_rst(sleep_rst),
  .sleep_enter(sleep_enter), .sleep_exit(sleep_exit), .power_loss(power_loss),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_do(pad_do), .run_dir(run_dir),
  .slp_dir(slp_dir), .hold_lat(hold_lat), .hold(hold)
);

// File: tb/sim_pin_hold_ctl.sv
module sim_pin_hold_ctl;
  localparam logic [21:0] MASK = 22'h3FFFFF;

  logic clk = 0;
  logic hard_rst = 1, soft_rst = 0, sleep_rst = 0, sleep_enter = 0, sleep_exit = 0, power_loss = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic [21:0] per_oe = '0, per_do = '0, pad_oe, pad_do;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_hold_ctl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    hard_rst = 0;
    @(negedge clk);
    chk("R1 idle rdata", bus_rdata, 0);
    rd(8'h00, rv); chk("R3 run after hard", rv, 0);
    rd(8'h0C, rv); chk("R5 sleep dir after hard", rv, {10'b0, MASK});
    rd(8'h10, rv); chk("R5 hold after hard", rv, 0);
    per_oe = MASK; @(negedge clk);
    chk("R3 pads inputs", {10'b0, pad_oe}, 0);

    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, rv); chk("R2 sleep reserved", rv, {10'b0, MASK});
    wr(8'h00, 32'hFFC0_0000); rd(8'h00, rv); chk("R2 run reserved", rv, 0);
    wr(8'h10, 32'hFFFF_FFFE); rd(8'h10, rv); chk("R2 hold reserved", rv, 0);
    @(negedge clk); chk("R1 rdata zero after read", bus_rdata, 0);

    for (int i = 0; i < 22; i++) begin
      wr(8'h00, 32'(22'(1) << i));
      per_oe = MASK; per_do = 22'(1) << (21 - i); @(negedge clk);
      chk("R10 oe by direction", {10'b0, pad_oe}, 32'(22'(1) << i));
      chk("R10 data pass", {10'b0, pad_do}, 32'(22'(1) << (21 - i)));
      per_oe = MASK & ~(22'(1) << i); @(negedge clk);
      chk("R10 oe by peripheral", {10'b0, pad_oe}, 0);
    end

    wr(8'h00, {10'b0, MASK}); wr(8'h0C, 32'h0012_3456);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    rd(8'h00, rv); chk("R3 soft clears run", rv, 0);
    rd(8'h0C, rv); chk("R4 soft keeps sleep dir", rv, 32'h0012_3456);
    wr(8'h00, {10'b0, MASK});
    sleep_rst = 1; @(negedge clk); sleep_rst = 0;
    rd(8'h00, rv); chk("R3 sleep reset clears run", rv, 0);
    rd(8'h0C, rv); chk("R4 sleep reset keeps sleep dir", rv, 32'h0012_3456);

    for (int i = 0; i < 22; i++) begin
      wr(8'h00, {10'b0, MASK});
      wr(8'h0C, {10'b0, MASK & ~(22'(1) << i)});
      per_oe = MASK; per_do = MASK;
      sleep_enter = 1; @(negedge clk); sleep_enter = 0;
      chk("R6 driven pin", {10'b0, pad_oe}, 32'(22'(1) << i));
      chk("R6 driven low", {10'b0, pad_do}, 0);
      wr(8'h0C, {10'b0, MASK});
      chk("R7 latch holds", {10'b0, pad_oe}, 32'(22'(1) << i));
      sleep_exit = 1; @(negedge clk); sleep_exit = 0;
      rd(8'h10, rv); chk("R8 hold set", rv, 1);
      per_oe = '0; per_do = 22'h15_5555; @(negedge clk);
      chk("R8 peripheral ignored oe", {10'b0, pad_oe}, 32'(22'(1) << i));
      chk("R8 peripheral ignored do", {10'b0, pad_do}, 0);
      wr(8'h10, 0); rd(8'h10, rv); chk("R9 zero write keeps hold", rv, 1);
      rd(8'h00, rv); chk("R3 sleep entry clears run", rv, 0);
      wr(8'h10, 1); rd(8'h10, rv); chk("R9 one write clears hold", rv, 0);
      per_oe = MASK; @(negedge clk);
      chk("R10 released run zero", {10'b0, pad_oe}, 0);
      chk("R10 released data", {10'b0, pad_do}, 32'h0015_5555);
    end

    wr(8'h0C, 0);
    sleep_enter = 1; @(negedge clk); sleep_enter = 0;
    chk("R6 all driven", {10'b0, pad_oe}, {10'b0, MASK});
    power_loss = 1; @(negedge clk); power_loss = 0;
    chk("R11 power loss inputs", {10'b0, pad_oe}, 0);
    sleep_exit = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h10; bus_wdata = 1;
    @(negedge clk);
    sleep_exit = 0; bus_sel = 0; bus_wr = 0;
    rd(8'h10, rv); chk("R9 exit beats clear", rv, 1);
    chk("R11 still inputs after wake", {10'b0, pad_oe}, 0);

    hard_rst = 1; @(negedge clk); hard_rst = 0;
    rd(8'h10, rv); chk("R5 hard clears hold", rv, 0);
    rd(8'h0C, rv); chk("R5 hard sets sleep dir", rv, {10'b0, MASK});
    chk("R5 pads follow run", {10'b0, pad_oe}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule